// File: doc/BRIEF.md
# Four-Bank SDRAM Command Scheduler

This block is the command front end of a controller for a synchronous DRAM with four internal banks. Requests arrive on a single port, each one naming a bank, a direction, a row and a column. Every bank owns a one-deep request slot. A fixed-priority picker chooses among the occupied slots. A row tracker remembers which row, if any, is open in each bank. A main sequencer turns the chosen request into the ACTIVE, PRECHARGE and column commands it needs and drives the row-strobe, column-strobe and write-enable pins plus the bank and address lines.

A free-running interval counter raises a refresh demand. Refresh is served ahead of any bank request: open banks are closed with a precharge-all first, then AUTO REFRESH is issued. Device initialization and the data path are handled elsewhere. Chip select is assumed tied low.

Top module: `sdram_cmd_sched`

## Requirements
- R1: While reset is asserted and right after it is released, the pins carry NOP and `bank_pending` is all zero.
- R2: A request loads into its bank's slot only when that slot is empty. `bank_pending[b]` is high from the clock after the load until the column command for bank b. A request aimed at an occupied slot is dropped and never produces a command.
- R3: When several slots are occupied at a decision point, the lowest-numbered bank is served first.
- R4: A request to a bank with no open row produces ACTIVE with the row on the address lines. It is followed exactly T_RCD clocks later by READ or WRITE with the column on the address lines and address bit 10 low. `bank_pending` for that bank drops with the column command.
- R5: A request whose row is already open in its bank produces only the column command, with no ACTIVE or PRECHARGE.
- R6: A request to a bank holding a different open row produces PRECHARGE for that bank only (address bit 10 low). ACTIVE for the new row follows exactly T_RP clocks later, and the column command follows T_RCD clocks after that.
- R7: Command encoding on {ras_n, cas_n, we_n}: ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, AUTO REFRESH 001, NOP 111. No other code appears.
- R8: A refresh demand is raised every T_REFI clocks and is served before any waiting bank request. If any bank is open, PRECHARGE with address bit 10 high comes first and AUTO REFRESH follows exactly T_RP clocks later; otherwise AUTO REFRESH is issued directly. After AUTO REFRESH the next command comes no sooner than T_RFC+1 clocks, and exactly then if work is waiting.
- R9: From an idle sequencer, the first command for a request appears on the pins two clocks after the request is presented: one clock to load the slot, one to decide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_bank | input | BA_W | Target bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| bank_pending | output | NB | Slot occupied, one bit per bank |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Row/column address, bit 10 selects all banks on precharge |

## Verification
The hardest situation to reach is a refresh demand and a bank request arriving at the same decision point. The refresh counter is not visible at the ports. The bench locks onto its phase by timing the gap between two idle AUTO REFRESH commands. It then presents a request so that the request loads on the exact clock the next demand is raised, and checks that AUTO REFRESH wins and ACTIVE follows T_RFC+1 clocks later. Priority is reached by filling three slots while an earlier request is still in its T_RCD wait, so that they all contend at one decision.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010,
    CMD_REF = 3'b001,
    CMD_NOP = 3'b111
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREW,
    ST_ACTW,
    ST_REFW
  } seq_st_t;
endpackage

// File: rtl/bank_slot.sv
module bank_slot #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             clr,
  input  logic             in_wr,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  output logic             busy,
  output logic             wr,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic take;
  assign take = ld && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else if (take) busy <= 1'b1;
    else if (clr) busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr  <= 1'b0;
      row <= '0;
      col <= '0;
    end else if (take) begin
      wr  <= in_wr;
      row <= in_row;
      col <= in_col;
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NB = 4,
  localparam int IW = $clog2(NB)
) (
  input  logic [NB-1:0] req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/row_track.sv
module row_track #(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  localparam int IW   = $clog2(NB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act,
  input  logic                     pre,
  input  logic                     pre_all,
  input  logic [IW-1:0]            bank,
  input  logic [ROW_W-1:0]         row,
  output logic [NB-1:0]            open_vld,
  output logic [NB-1:0][ROW_W-1:0] open_row
);
  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic hit;
    assign hit = (bank == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_vld[g] <= 1'b0;
      else if (pre_all || (pre && hit)) open_vld[g] <= 1'b0;
      else if (act && hit) open_vld[g] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_row[g] <= '0;
      else if (act && hit) open_row[g] <= row;
    end
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import sched_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 3,
  parameter int T_RFC  = 7,
  parameter int T_REFI = 1560,
  localparam int IW    = $clog2(NB),
  localparam int TMAX  = (T_RP > T_RCD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                        : ((T_RCD > T_RFC) ? T_RCD : T_RFC),
  localparam int CW    = $clog2(TMAX + 1),
  localparam int RW    = $clog2(T_REFI + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pick_any,
  input  logic [IW-1:0]            pick_idx,
  input  logic [NB-1:0]            slot_wr,
  input  logic [NB-1:0][ROW_W-1:0] slot_row,
  input  logic [NB-1:0][COL_W-1:0] slot_col,
  input  logic [NB-1:0]            open_vld,
  input  logic [NB-1:0][ROW_W-1:0] open_row,
  output logic [NB-1:0]            slot_clr,
  output logic                     trk_act,
  output logic                     trk_pre,
  output logic                     trk_pre_all,
  output logic [IW-1:0]            trk_bank,
  output logic [ROW_W-1:0]         trk_row,
  output cmd_t                     cmd_q,
  output logic [IW-1:0]            ba_q,
  output logic [ADDR_W-1:0]        addr_q
);
  seq_st_t          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    cur_q, cur_d;
  logic             tref_q, tref_d;
  logic             rpend_q, rpend_d, ref_take, ref_hit;
  logic [RW-1:0]    refi_q, refi_d;
  cmd_t             cmd_d;
  logic [IW-1:0]    ba_d;
  logic [ADDR_W-1:0] addr_d;

  // refresh interval counter
  assign ref_hit = (refi_q == RW'(T_REFI - 1));
  assign refi_d  = ref_hit ? '0 : refi_q + 1'b1;
  assign rpend_d = ref_hit || (rpend_q && !ref_take);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; cur_d = cur_q; tref_d = tref_q;
    cmd_d = CMD_NOP; ba_d = '0; addr_d = '0;
    slot_clr = '0; trk_act = 1'b0; trk_pre = 1'b0; trk_pre_all = 1'b0;
    trk_bank = '0; trk_row = '0; ref_take = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rpend_q) begin
          if (|open_vld) begin
            cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1;
            trk_pre_all = 1'b1; tref_d = 1'b1;
            cnt_d = CW'(T_RP - 1); st_d = ST_PREW;
          end else begin
            cmd_d = CMD_REF; ref_take = 1'b1;
            cnt_d = CW'(T_RFC - 1); st_d = ST_REFW;
          end
        end else if (pick_any) begin
          cur_d = pick_idx; ba_d = pick_idx; trk_bank = pick_idx;
          if (open_vld[pick_idx] && open_row[pick_idx] == slot_row[pick_idx]) begin
            cmd_d = slot_wr[pick_idx] ? CMD_WR : CMD_RD;
            addr_d = ADDR_W'(slot_col[pick_idx]);
            slot_clr[pick_idx] = 1'b1;
          end else if (open_vld[pick_idx]) begin
            cmd_d = CMD_PRE; trk_pre = 1'b1; tref_d = 1'b0;
            cnt_d = CW'(T_RP - 1); st_d = ST_PREW;
          end else begin
            cmd_d = CMD_ACT; addr_d = ADDR_W'(slot_row[pick_idx]);
            trk_act = 1'b1; trk_row = slot_row[pick_idx];
            cnt_d = CW'(T_RCD - 1); st_d = ST_ACTW;
          end
        end
      end
      ST_PREW: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (tref_q) begin
          cmd_d = CMD_REF; ref_take = 1'b1;
          cnt_d = CW'(T_RFC - 1); st_d = ST_REFW;
        end else begin
          cmd_d = CMD_ACT; ba_d = cur_q; addr_d = ADDR_W'(slot_row[cur_q]);
          trk_act = 1'b1; trk_bank = cur_q; trk_row = slot_row[cur_q];
          cnt_d = CW'(T_RCD - 1); st_d = ST_ACTW;
        end
      end
      ST_ACTW: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          cmd_d = slot_wr[cur_q] ? CMD_WR : CMD_RD;
          ba_d = cur_q; addr_d = ADDR_W'(slot_col[cur_q]);
          slot_clr[cur_q] = 1'b1; st_d = ST_IDLE;
        end
      end
      ST_REFW: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; cur_q <= '0; tref_q <= 1'b0;
      rpend_q <= 1'b0; refi_q <= '0;
      cmd_q <= CMD_NOP; ba_q <= '0; addr_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; cur_q <= cur_d; tref_q <= tref_d;
      rpend_q <= rpend_d; refi_q <= refi_d;
      cmd_q <= cmd_d; ba_q <= ba_d; addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
  import sched_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 3,
  parameter int T_RFC  = 7,
  parameter int T_REFI = 1560,
  localparam int BA_W  = $clog2(NB),
  localparam int ADDR_W = (ROW_W > AP_BIT + 1) ? ROW_W : AP_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BA_W-1:0]   req_bank,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [NB-1:0]     bank_pending,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  logic [NB-1:0]            s_busy, s_wr, s_clr;
  logic [NB-1:0][ROW_W-1:0] s_row, trk_orow;
  logic [NB-1:0][COL_W-1:0] s_col;
  logic [NB-1:0]            trk_vld;
  logic                     p_any, t_act, t_pre, t_pall;
  logic [BA_W-1:0]          p_idx, t_bank;
  logic [ROW_W-1:0]         t_row;
  cmd_t                     cmd;

  for (genvar g = 0; g < NB; g++) begin : g_slot
    bank_slot #(.ROW_W(ROW_W), .COL_W(COL_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .ld(req_valid && req_bank == BA_W'(g)), .clr(s_clr[g]),
      .in_wr(req_write), .in_row(req_row), .in_col(req_col),
      .busy(s_busy[g]), .wr(s_wr[g]), .row(s_row[g]), .col(s_col[g])
    );
  end

  prio_pick #(.NB(NB)) u_pick (.req(s_busy), .any(p_any), .idx(p_idx));

  row_track #(.NB(NB), .ROW_W(ROW_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .act(t_act), .pre(t_pre), .pre_all(t_pall),
    .bank(t_bank), .row(t_row), .open_vld(trk_vld), .open_row(trk_orow)
  );

  cmd_seq #(
    .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pick_any(p_any), .pick_idx(p_idx),
    .slot_wr(s_wr), .slot_row(s_row), .slot_col(s_col),
    .open_vld(trk_vld), .open_row(trk_orow), .slot_clr(s_clr),
    .trk_act(t_act), .trk_pre(t_pre), .trk_pre_all(t_pall),
    .trk_bank(t_bank), .trk_row(t_row),
    .cmd_q(cmd), .ba_q(sd_ba), .addr_q(sd_addr)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign bank_pending = s_busy;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic [NB-1:0]   pend,
  input logic [NB-1:0]   open_vld
);
  logic [2:0] c;
  logic col, refc;
  assign c    = {ras_n, cas_n, we_n};
  assign col  = (c == 3'b101) || (c == 3'b100);
  assign refc = (c == 3'b001);

  // R7
  a_r7_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    c inside {3'b011, 3'b101, 3'b100, 3'b010, 3'b001, 3'b111});

  // R4: slot is released together with its column command
  a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> !pend[ba]);

  // R4/R5: column commands only go to a bank with an open row
  a_r5_col_open: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> open_vld[ba]);

  // R8: refresh only with every bank closed
  a_r8_ref_closed: assert property (@(posedge clk) disable iff (!rst_n)
    refc |-> open_vld == '0);

  // R8: the clock after AUTO REFRESH is idle
  a_r8_rfc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    refc |=> c == 3'b111);
endmodule

bind sdram_cmd_sched sched_chk #(.NB(NB), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
  .ba(sd_ba), .pend(bank_pending), .open_vld(trk_vld)
);

// File: tb/sdram_cmd_sched_bench.sv
module sdram_cmd_sched_bench;
  localparam int TRP = 2, TRCD = 3, TRFC = 4, TREFI = 200;
  localparam int ROW_W = 13, COL_W = 10, ADDR_W = 13;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [3:0] bank_pending;
  logic ras_n, cas_n, we_n;
  logic [1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  sdram_cmd_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RP(TRP), .T_RCD(TRCD),
                    .T_RFC(TRFC), .T_REFI(TREFI)) u_sdram_cmd_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .bank_pending(bank_pending), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // expected requests, written by the stimulus, consumed by the monitor
  int exp_seq[4], done_seq[4], exp_row[4], exp_col[4], exp_wr[4];
  initial for (int i = 0; i < 4; i++) begin exp_seq[i] = 0; exp_row[i] = 0; exp_col[i] = 0; exp_wr[i] = 0; end

  // protocol model
  logic [2:0] cmd;
  assign cmd = {ras_n, cas_n, we_n};
  bit mopen[4];
  int mrow[4], lpre[4], lact[4], lref;
  initial begin
    for (int i = 0; i < 4; i++) begin mopen[i] = 0; mrow[i] = 0; lpre[i] = -1000; lact[i] = -1000; done_seq[i] = 0; end
    lref = -1000;
  end

  always @(negedge clk) if (rst_n) begin
    int b;
    b = int'(sd_ba);
    case (cmd)
      C_ACT: begin
        check(!mopen[b], "R4 ACTIVE to closed bank", int'(mopen[b]), 0);
        check(cyc - lpre[b] >= TRP, "R6 ACTIVE after PRECHARGE gap", cyc - lpre[b], TRP);
        check(cyc - lref > TRFC, "R8 ACTIVE after REFRESH gap", cyc - lref, TRFC + 1);
        mopen[b] = 1; mrow[b] = int'(sd_addr); lact[b] = cyc;
      end
      C_RD, C_WR: begin
        check(mopen[b], "R4 column to open bank", int'(mopen[b]), 1);
        check(cyc - lact[b] >= TRCD, "R4 column after ACTIVE gap", cyc - lact[b], TRCD);
        check(exp_seq[b] != done_seq[b], "R2 column without accepted request", 1, 0);
        check(mrow[b] == exp_row[b], "R4 open row matches request", mrow[b], exp_row[b]);
        check(int'(sd_addr) == exp_col[b], "R4 column address", int'(sd_addr), exp_col[b]);
        check(int'(cmd == C_WR) == exp_wr[b], "R7 read/write code", int'(cmd == C_WR), exp_wr[b]);
        done_seq[b]++;
      end
      C_PRE: begin
        if (sd_addr[10]) for (int i = 0; i < 4; i++) begin mopen[i] = 0; lpre[i] = cyc; end
        else begin
          check(mopen[b], "R6 single-bank PRECHARGE to open bank", int'(mopen[b]), 1);
          mopen[b] = 0; lpre[b] = cyc;
        end
      end
      C_REF: begin
        check(!(mopen[0] | mopen[1] | mopen[2] | mopen[3]), "R8 REFRESH with banks closed", 1, 0);
        for (int i = 0; i < 4; i++) check(cyc - lpre[i] >= TRP, "R8 REFRESH after precharge gap", cyc - lpre[i], TRP);
        lref = cyc;
      end
      C_NOP: ;
      default: check(0, "R7 illegal command code", int'(cmd), 7);
    endcase
  end

  int t_sent;
  task automatic send(input int b, input bit wr, input int row, input int col, input bit accept);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(b); req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    t_sent = cyc;
    if (accept) begin exp_row[b] = row; exp_col[b] = col; exp_wr[b] = int'(wr); exp_seq[b]++; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic next_cmd(output logic [2:0] c, output int b, output int a, output int t);
    int k = 0;
    c = C_NOP; b = 0; a = 0; t = 0;
    do begin
      @(negedge clk); k++;
    end while (cmd == C_NOP && k < 600);
    c = cmd; b = int'(sd_ba); a = int'(sd_addr); t = cyc;
    if (cmd == C_NOP) check(0, "watchdog: no command", 0, 1);
  endtask

  task automatic wait_ref(output int t);
    logic [2:0] c; int b, a;
    do next_cmd(c, b, a, t); while (c != C_REF);
    repeat (TRFC + 2) @(negedge clk);
  endtask

  initial begin
    #200_000_000;
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [2:0] c; int b, a, t, t0, tp, r1, r2, r3;
    int order[4]; int k;
    repeat (3) @(negedge clk);
    check(cmd == C_NOP, "R1 NOP in reset", int'(cmd), int'(C_NOP));
    check(bank_pending == 0, "R1 no pending in reset", int'(bank_pending), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(cmd == C_NOP, "R1 NOP after reset", int'(cmd), int'(C_NOP));
    check(bank_pending == 0, "R1 no pending after reset", int'(bank_pending), 0);

    // closed bank, row hit, row miss
    wait_ref(t);
    send(1, 0, 5, 7, 1); t0 = t_sent;
    @(negedge clk);
    check(bank_pending == 4'b0010, "R2 pending flag after load", int'(bank_pending), 2);
    next_cmd(c, b, a, t);
    check(c == C_ACT && b == 1 && a == 5, "R4 ACTIVE row 5 bank 1", int'(c), int'(C_ACT));
    check(t == t0 + 2, "R9 two-clock latency", t - t0, 2);
    tp = t;
    next_cmd(c, b, a, t);
    check(c == C_RD && t == tp + TRCD, "R4 READ after tRCD", t - tp, TRCD);
    check(bank_pending == 0, "R4 pending cleared by column", int'(bank_pending), 0);
    send(1, 1, 5, 9, 1); t0 = t_sent;
    next_cmd(c, b, a, t);
    check(c == C_WR && b == 1 && t == t0 + 2, "R5 row hit gives WRITE only", int'(c), int'(C_WR));
    send(1, 0, 6, 3, 1); t0 = t_sent;
    next_cmd(c, b, a, t);
    check(c == C_PRE && b == 1 && a[10] == 1'b0, "R6 single-bank PRECHARGE", int'(c), int'(C_PRE));
    tp = t;
    next_cmd(c, b, a, t);
    check(c == C_ACT && a == 6 && t == tp + TRP, "R6 ACTIVE after exactly tRP", t - tp, TRP);
    tp = t;
    next_cmd(c, b, a, t);
    check(c == C_RD && t == tp + TRCD, "R6 READ after exactly tRCD", t - tp, TRCD);

    // priority and dropped request
    wait_ref(t);
    send(3, 0, 1, 1, 1);
    send(2, 0, 2, 2, 1);
    send(1, 0, 3, 3, 1);
    send(0, 1, 4, 4, 1);
    send(0, 0, 9, 85, 0);
    check(bank_pending[0] == 1'b1, "R2 bank 0 still holds first request", int'(bank_pending[0]), 1);
    k = 0;
    while (k < 4) begin
      next_cmd(c, b, a, t);
      if (c == C_RD || c == C_WR) begin order[k] = b; k++; end
    end
    check(order[0] == 3, "R3 in-flight bank 3 first", order[0], 3);
    check(order[1] == 0, "R3 bank 0 highest", order[1], 0);
    check(order[2] == 1, "R3 bank 1 next", order[2], 1);
    check(order[3] == 2, "R3 bank 2 last", order[3], 2);
    repeat (20) @(negedge clk);
    check(done_seq[0] == exp_seq[0], "R2 dropped request issued nothing", done_seq[0], exp_seq[0]);
    check(bank_pending == 0, "R2 all slots empty", int'(bank_pending), 0);

    // refresh with open banks, interval, priority
    next_cmd(c, b, a, t);
    check(c == C_PRE && a[10] == 1'b1, "R8 precharge-all before refresh", int'(c), int'(C_PRE));
    tp = t;
    next_cmd(c, b, a, t);
    check(c == C_REF && t == tp + TRP, "R8 REFRESH tRP after precharge-all", t - tp, TRP);
    r1 = t;
    next_cmd(c, b, a, t);
    check(c == C_REF && t - r1 == TREFI - TRP, "R8 refresh interval", t - r1, TREFI - TRP);
    r2 = t;
    while (cyc < r2 + TREFI - 3) @(negedge clk);
    send(2, 1, 11, 12, 1);
    next_cmd(c, b, a, t);
    check(c == C_REF && t == r2 + TREFI, "R8 refresh wins over request", t - r2, TREFI);
    r3 = t;
    next_cmd(c, b, a, t);
    check(c == C_ACT && b == 2 && t == r3 + TRFC + 1, "R8 ACTIVE tRFC+1 after REFRESH", t - r3, TRFC + 1);
    next_cmd(c, b, a, t);
    check(c == C_WR && b == 2, "R4 WRITE after refresh", int'(c), int'(C_WR));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule